// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port

This block models the digital side of a 14-bit sampling converter as a synthesizable unit. A host drives three pins: a convert strobe, a serial clock and a serial data input. The block answers on one serial data output that has its own drive enable. The strobe, the clock and the data input are taken into the system clock domain through synchronizer chains, and edges are detected there. The converted value does not come from analog circuitry. It is read from a parallel sample port when the strobe rises, limited to the 14-bit code range, and shifted out once a conversion timer of fixed length has expired.

Each rising edge of the strobe chooses the port behaviour for that conversion. If the data input is high, the port runs in select mode: the strobe or the data input, whichever is low, enables the output. If the data input is low, the port runs in chain mode, where several ports share one output line. The serial clock level at that edge turns the chain-mode ready indication on or off. In select mode, the ready indication is on when the port is already selected at the moment the conversion ends.

The controller has three named states. IDLE is the state after reset. CONV runs the conversion timer. READY holds a finished result. The transitions are: IDLE to CONV on a strobe rise (start), CONV to READY when the timer expires (finish), and READY to CONV on a strobe rise (restart). A strobe rise while in CONV causes no transition.

Top module: `sar_serial_port`

## Requirements
- R1: At a synchronized strobe rise, a high data input selects select mode and a low data input selects chain mode. The mode holds until the next accepted strobe rise.
- R2: In chain mode, a high serial clock at the strobe rise enables the ready indication and a low one disables it. With it disabled, the code MSB is on the output as soon as READY is entered.
- R3: In select mode, if the strobe or the data input is low when the conversion finishes, the output is driven low as a start bit before the MSB. The start bit is consumed by the first serial clock falling edge.
- R4: In the cycle a strobe rise is detected, the output enable is low. A strobe rise during CONV neither restarts nor shortens the conversion, and it does not replace the captured sample.
- R5: CONV lasts CONV_CYC system clocks. With two synchronizer stages, the first driven output of a selected select-mode port appears CONV_CYC+3 clocks after the strobe pin rises.
- R6: The code is unsigned straight binary, sent MSB first. Each serial clock falling edge seen while the port is enabled moves the output to the next bit.
- R7: In select mode, the output enable drops after the 14th data falling edge (the 15th with a start bit), or as soon as the strobe and the data input are both high.
- R8: In chain mode, the data input level present at each serial clock falling edge in READY appears on the output 14 falling edges later, after the 14 code bits.
- R9: In chain mode during CONV, the output is driven low when the strobe and the data input are both low. Otherwise it is not driven.
- R10: In chain mode with the ready indication, READY first drives the output with the data input level: low stays low, high passes high. The first falling edge consumes this slot and exposes the MSB.
- R11: A sample of 0x3FFF or above yields code 0x3FFF. Smaller samples pass unchanged, and 0x0000 yields 0x0000.
- R12: After reset the port is in IDLE and the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe pin (asynchronous) |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data / select pin (asynchronous) |
| sample_i | input | IN_W (16) | Unsigned sample value captured at a strobe rise |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for the serial output (low means high impedance) |

## Verification
The bench goes after several timing and protocol cases. It measures the exact clock at which the output first drives after a strobe rise; an extra or missing register stage shifts that count. It pulses the strobe again during a conversion with a different sample on the port; a design that restarts the conversion drives late and returns the second value. It deselects a select-mode frame partway through and counts the falling edges that end a frame with and without a start bit; an off-by-one frame length leaves the output driven or cuts off the LSB. It pushes a pattern through chain mode and checks that it appears exactly 14 edges behind, checks how the ready slot ripples a high level, and sends samples at and above the code ceiling, where a missing clamp returns wrapped low bits.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2
    } conv_state_t;

endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign level = pipe[STAGES-1];

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_port_pkg::*;
#(
    parameter int CONV_CYC = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnv_rise,
    output conv_state_t state,
    output logic        done
);

    localparam int CW = $clog2(CONV_CYC + 1);

    conv_state_t    nxt;
    logic [CW-1:0]  timer;

    assign done = (state == ST_CONV) && (timer == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions: start, finish, restart
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cnv_rise) nxt = ST_CONV;
            ST_CONV:  if (done)     nxt = ST_READY;
            ST_READY: if (cnv_rise) nxt = ST_CONV;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (state != ST_CONV && cnv_rise) begin
            timer <= CW'(CONV_CYC - 1);
        end else if (state == ST_CONV && timer != '0) begin
            timer <= timer - CW'(1);
        end
    end

endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift
    import sar_port_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy_in,
    input  logic              chain_mode,
    input  logic [DATA_W-1:0] code,
    input  conv_state_t       state,
    input  logic              cnv_lv,
    input  logic              sdi_lv,
    input  logic              cnv_rise,
    input  logic              sck_fall,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int              CNTW = $clog2(DATA_W + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic              lead;
    logic [CNTW-1:0]   sent;
    logic              sel;
    logic              shift_en;
    logic              in_bit;

    assign sel      = ~cnv_lv | ~sdi_lv;
    assign shift_en = (state == ST_READY) && sck_fall && (chain_mode || sel);
    assign in_bit   = chain_mode & sdi_lv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            lead  <= 1'b0;
            sent  <= '0;
        end else if (load) begin
            shreg <= code;
            lead  <= busy_in;
            sent  <= '0;
        end else if (shift_en) begin
            if (lead) begin
                lead <= 1'b0;
            end else begin
                shreg <= {shreg[DATA_W-2:0], in_bit};
                if (sent != LAST) sent <= sent + CNTW'(1);
            end
        end
    end

    // output drive per state
    always_comb begin
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sdo_oe = 1'b0;
            end
            ST_CONV: begin
                sdo_oe = chain_mode & ~sdi_lv & ~cnv_lv;
            end
            ST_READY: begin
                if (chain_mode) begin
                    sdo_oe = 1'b1;
                    sdo    = lead ? sdi_lv : shreg[DATA_W-1];
                end else begin
                    sdo_oe = sel && (sent != LAST);
                    sdo    = lead ? 1'b0 : shreg[DATA_W-1];
                end
            end
            default: begin
                sdo_oe = 1'b0;
            end
        endcase
        if (cnv_rise) sdo_oe = 1'b0;
    end

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_port_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int IN_W        = 16,
    parameter int CONV_CYC    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnv_i,
    input  logic            sck_i,
    input  logic            sdi_i,
    input  logic [IN_W-1:0] sample_i,
    output logic            sdo_o,
    output logic            sdo_oe_o
);

    localparam int              NPINS    = 3;
    localparam logic [IN_W-1:0] CODE_MAX = IN_W'((2 ** DATA_W) - 1);

    logic [NPINS-1:0]  raw_in;
    logic [NPINS-1:0]  lv;
    logic              cnv_lv, sck_lv, sdi_lv;
    logic              cnv_q, sck_q;
    logic              cnv_rise, sck_fall;
    logic              chain_q, chain_busy_q;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] sat_code;
    logic              busy_at_done;
    logic              done;
    conv_state_t       state;

    assign raw_in = {cnv_i, sck_i, sdi_i};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        sar_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .level (lv[g])
        );
    end

    assign cnv_lv = lv[2];
    assign sck_lv = lv[1];
    assign sdi_lv = lv[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            cnv_q <= cnv_lv;
            sck_q <= sck_lv;
        end
    end

    assign cnv_rise = cnv_lv & ~cnv_q;
    assign sck_fall = ~sck_lv & sck_q;

    assign sat_code = (sample_i >= CODE_MAX) ? DATA_W'(CODE_MAX) : sample_i[DATA_W-1:0];

    // mode and sample capture on an accepted strobe rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q      <= 1'b0;
            chain_busy_q <= 1'b0;
            code_q       <= '0;
        end else if (cnv_rise && state != ST_CONV) begin
            chain_q      <= ~sdi_lv;
            chain_busy_q <= sck_lv;
            code_q       <= sat_code;
        end
    end

    assign busy_at_done = chain_q ? chain_busy_q : (~cnv_lv | ~sdi_lv);

    sar_conv_ctrl #(.CONV_CYC(CONV_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_rise (cnv_rise),
        .state    (state),
        .done     (done)
    );

    sar_out_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (done),
        .busy_in    (busy_at_done),
        .chain_mode (chain_q),
        .code       (code_q),
        .state      (state),
        .cnv_lv     (cnv_lv),
        .sdi_lv     (sdi_lv),
        .cnv_rise   (cnv_rise),
        .sck_fall   (sck_fall),
        .sdo        (sdo_o),
        .sdo_oe     (sdo_oe_o)
    );

endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk
    import sar_port_pkg::*;
#(
    parameter int CONV_CYC = 40
) (
    input logic        clk,
    input logic        rst_n,
    input conv_state_t state,
    input logic        chain_q,
    input logic        cnv_lv,
    input logic        sdi_lv,
    input logic        cnv_rise,
    input logic        sdo,
    input logic        sdo_oe
);

    logic [31:0] conv_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_len <= '0;
        end else if (state == ST_CONV) begin
            conv_len <= conv_len + 32'd1;
        end else begin
            conv_len <= '0;
        end
    end

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo_oe);

    // R4
    rise_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rise |-> !sdo_oe);

    // R4
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_len < 32'(CONV_CYC - 1)) |=> (state == ST_CONV));

    // R5
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && $past(state) == ST_CONV) |-> (conv_len == 32'(CONV_CYC)));

    // R9
    chain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && chain_q && !sdi_lv && !cnv_lv) |-> (sdo_oe && !sdo));

    // R7
    cs_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_q && cnv_lv && sdi_lv) |-> !sdo_oe);

endmodule

bind sar_serial_port sar_serial_port_chk #(.CONV_CYC(CONV_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .chain_q  (chain_q),
    .cnv_lv   (cnv_lv),
    .sdi_lv   (sdi_lv),
    .cnv_rise (cnv_rise),
    .sdo      (sdo_o),
    .sdo_oe   (sdo_oe_o)
);

// File: tb/sar_serial_port_tb_top.sv
module sar_serial_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 40;
    localparam int SETTLE     = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnv, sck, sdi;
    logic [15:0] sample;
    logic        sdo, oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_serial_port #(.CONV_CYC(CONV_CYC)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv),
        .sck_i    (sck),
        .sdi_i    (sdi),
        .sample_i (sample),
        .sdo_o    (sdo),
        .sdo_oe_o (oe)
    );

    function automatic logic [13:0] exp_code(logic [15:0] s);
        return (s >= 16'h3FFF) ? 14'h3FFF : s[13:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(logic c, logic k, logic d);
        cnv = c; sck = k; sdi = d;
        tick(SETTLE);
    endtask

    task automatic fall_edge();
        pins(cnv, 1'b1, sdi);
        pins(cnv, 1'b0, sdi);
    endtask

    task automatic start(logic [15:0] s, logic mode_sdi, logic mode_sck);
        sample = s;
        pins(1'b0, mode_sck, mode_sdi);
        pins(1'b1, mode_sck, mode_sdi);
    endtask

    // select mode frame, port already selected
    task automatic cs_frame(bit busy, logic [13:0] code, string req);
        if (busy) begin
            chk("R3 start bit oe", oe, 1);
            chk("R3 start bit level", sdo, 0);
            fall_edge();
        end
        for (int i = 13; i >= 0; i--) begin
            chk({req, " oe"}, oe, 1);
            chk({req, " bit"}, sdo, code[i]);
            fall_edge();
        end
        chk("R7 end of frame", oe, 0);
    endtask

    task automatic chain_frame(logic [13:0] code);
        for (int i = 13; i >= 0; i--) begin
            chk("R8 chain oe", oe, 1);
            chk("R6 chain bit", sdo, code[i]);
            pins(cnv, 1'b1, 1'b0);
            pins(cnv, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] s;
        logic [13:0] pat;
        int          got;
        int          m;

        void'($urandom(32'd20240611));
        cnv = 0; sck = 0; sdi = 1; sample = 16'h0; rst_n = 0;
        tick(4);
        rst_n = 1;
        tick(3);

        // R12 reset state
        chk("R12 reset oe", oe, 0);

        // R1 select mode, no start bit (deselected at finish)
        start(16'h2A5C, 1'b1, 1'b0);
        chk("R4 hi-z after rise", oe, 0);
        tick(CONV_CYC);
        chk("R7 deselected READY", oe, 0);
        pins(1'b0, 1'b0, 1'b1);
        cs_frame(0, exp_code(16'h2A5C), "R1");

        // R5 timing and R3 start bit, selected via data input
        sample = 16'h1234;
        pins(1'b0, 1'b0, 1'b1);
        cnv = 1'b1;
        got = -1;
        for (int k = 1; k <= CONV_CYC + 10; k++) begin
            @(negedge clk);
            if (k == 3) sdi = 1'b0;
            if (oe) begin
                got = k;
                break;
            end
        end
        chk("R5 first drive clock", got, CONV_CYC + 3);
        chk("R3 start bit level", sdo, 0);
        fall_edge();
        for (int i = 13; i >= 0; i--) begin
            if (i == 8) begin
                pins(1'b1, 1'b0, 1'b1);
                chk("R7 mid-frame deselect", oe, 0);
                pins(1'b1, 1'b0, 1'b0);
            end
            chk("R6 oe", oe, 1);
            chk("R6 bit", sdo, exp_code(16'h1234) >> i & 14'h1);
            fall_edge();
        end
        chk("R7 after 15th fall", oe, 0);

        // R9 chain conversion phase, R8 pass-through, R2 no ready slot
        start(16'h0F0F, 1'b0, 1'b0);
        chk("R9 cnv high", oe, 0);
        pins(1'b0, 1'b0, 1'b0);
        chk("R9 driven oe", oe, 1);
        chk("R9 driven low", sdo, 0);
        pins(1'b0, 1'b0, 1'b1);
        chk("R9 sdi high", oe, 0);
        pins(1'b0, 1'b0, 1'b0);
        tick(CONV_CYC);
        chk("R2 MSB at once", sdo, exp_code(16'h0F0F) >> 13 & 14'h1);
        pat = 14'h2B71;
        for (int k = 0; k < 28; k++) begin
            logic d;
            d = (k < 14) ? pat[13-k] : 1'b0;
            chk("R8 oe", oe, 1);
            if (k < 14) chk("R8 local bit", sdo, exp_code(16'h0F0F) >> (13-k) & 14'h1);
            else        chk("R8 passed bit", sdo, pat[13-(k-14)]);
            pins(1'b0, 1'b1, d);
            pins(1'b0, 1'b0, d);
        end

        // R10 chain with ready slot, R2 enabled by serial clock
        start(16'h3A01, 1'b0, 1'b1);
        pins(1'b1, 1'b0, 1'b0);
        tick(CONV_CYC);
        chk("R10 slot oe", oe, 1);
        chk("R10 slot low", sdo, 0);
        pins(1'b1, 1'b0, 1'b1);
        chk("R10 slot high", sdo, 1);
        pins(1'b1, 1'b1, 1'b1);
        pins(1'b1, 1'b0, 1'b1);
        chain_frame(exp_code(16'h3A01));

        // R4 second rise during conversion is ignored
        start(16'h0155, 1'b1, 1'b0);
        tick(5);
        sample = 16'h3000;
        pins(1'b0, 1'b0, 1'b1);
        pins(1'b1, 1'b0, 1'b1);
        tick(CONV_CYC - 20 + 5);
        pins(1'b1, 1'b0, 1'b0);
        chk("R4 done on first timing", oe, 1);
        cs_frame(0, exp_code(16'h0155), "R4");

        // R11 clamping corners
        foreach (s[i]) begin end
        for (int j = 0; j < 5; j++) begin
            case (j)
                0: s = 16'hFFFF;
                1: s = 16'h3FFF;
                2: s = 16'h4000;
                3: s = 16'h3FFE;
                default: s = 16'h0000;
            endcase
            start(s, 1'b1, 1'b0);
            tick(CONV_CYC);
            pins(1'b0, 1'b0, 1'b1);
            cs_frame(0, exp_code(s), "R11");
        end

        // random mix of select and chain frames
        for (int r = 0; r < 12; r++) begin
            s = 16'($urandom);
            if (r % 4 == 0) s = s | 16'hC000;
            m = int'($urandom % 2);
            if (m == 0) begin
                start(s, 1'b1, 1'b0);
                tick(CONV_CYC);
                pins(1'b0, 1'b0, 1'b1);
                cs_frame(0, exp_code(s), "R6");
            end else begin
                start(s, 1'b0, 1'b0);
                tick(CONV_CYC);
                chain_frame(exp_code(s));
            end
        end

        summary();
        $finish;
    end

endmodule